// File: doc/BRIEF.md
# Local interrupt priority controller

This block holds the interrupt state of one processor across 256 vectors. Incoming vectors are latched into a pending set, and the block presents an interrupt request together with the highest vector that may be delivered. When the processor acknowledges, that vector moves from the pending set to the in-service set. An end-of-interrupt write retires the highest vector in service.

Every vector belongs to a priority class, which is its upper four bits. Software programs a task priority, and no vector whose class is at or below that value is delivered. A processor priority is derived from the task priority and the highest class in service, and it sets the threshold that a pending vector must exceed.

A small word-wide register port gives write access to the task priority. The same port reads the task priority, the processor priority, and the pending and in-service sets, each as eight 32-bit words.

Top module: `irq_prio_ctrl`

## Requirements
- R1: A synchronous active-high reset clears the pending set, the in-service set and the task priority, and drives irq_req, ack_valid and reg_rdata to zero.
- R2: An accept of vector v (acc_valid high) sets pending bit v, which reads back in pending word v/32 at bit v%32, so 0xF3 reads as 0x00080000 in word 7. An accept of a vector that is already pending has no further effect.
- R3: Accepts of vectors 0 to 15 (class 0) are ignored, and their pending bits never set.
- R4: The class of a vector is bits [7:4]. One cycle after any state change, irq_req is high exactly when the highest pending vector has a class strictly greater than the processor priority class, and irq_vec then carries that vector (zero when irq_req is low).
- R5: A pending vector whose class is less than or equal to the task priority class is never delivered. A task priority of 0xFF blocks every vector. A masked vector stays pending and is not placed in service.
- R6: The processor priority equals the task priority when the in-service set is empty or the task priority class is at least the highest in-service class. Otherwise it equals the highest in-service class in bits [7:4], with zeros in bits [3:0].
- R7: An ack pulse while a vector is deliverable clears that pending bit and sets the same in-service bit at the same clock edge, and on the next cycle drives ack_valid high with ack_vec equal to the vector. An ack with nothing deliverable changes no state and leaves ack_valid low.
- R8: An eoi_wr pulse clears the highest set in-service bit, and irq_req is re-evaluated from the new state on the following cycle. An eoi_wr with an empty in-service set has no effect.
- R9: The register port decodes reg_addr as 0 = task priority (read and write, bits [7:0]), 1 = processor priority (read only), 16+w = pending word w, 24+w = in-service word w. reg_rdata shows the addressed value from the state before the edge, one cycle after the address. Writes to any address other than 0 are ignored.
- R10: At one edge, an acknowledge applies before a new accept, and an end-of-interrupt applies before the acknowledged vector is placed in service. An accept of the vector being acknowledged therefore leaves it both pending and in service.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_valid | input | 1 | Vector accept strobe |
| acc_vec | input | 8 | Vector being accepted |
| ack | input | 1 | Processor acknowledge pulse |
| ack_valid | output | 1 | Registered: acknowledge took a vector |
| ack_vec | output | 8 | Registered: vector moved to in-service |
| eoi_wr | input | 1 | End-of-interrupt write pulse |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 5 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Registered read data |
| irq_req | output | 1 | Registered interrupt request to the processor |
| irq_vec | output | 8 | Registered highest deliverable vector |

## Verification
On every cycle, the assertions check that class-0 vectors never become pending, that a reported acknowledge is reflected in the in-service set, and that an end-of-interrupt removes the vector that was highest in service. They also check that the processor priority never falls below the task priority or the highest in-service class, and that any asserted request exceeds the previous processor priority. The bench's scenarios cover the exact word and bit placement of vectors, how duplicate accepts collapse, blocking by a task priority of 0xFF, the ordering of accept, acknowledge and end-of-interrupt within one cycle, and ignored writes. A behavioural reference model, compared on every clock during a long random phase, covers all of these together.

// File: rtl/irq_prio_pkg.sv
package irq_prio_pkg;
  // Register bank select, taken from the top two address bits.
  typedef enum logic [1:0] {
    BANK_CTL = 2'd0,
    BANK_NONE = 2'd1,
    BANK_PEND = 2'd2,
    BANK_SERV = 2'd3
  } bank_e;

  localparam int unsigned CTL_TPR = 0;
  localparam int unsigned CTL_PPR = 1;
endpackage

// File: rtl/irq_hi_find.sv
// Finds the highest set bit of a wide vector in two levels: within words, then across words.
module irq_hi_find #(
  parameter int unsigned NBITS  = 256,
  parameter int unsigned WORD_W = 32
) (
  input  logic [NBITS-1:0]         bits,
  output logic                     any,
  output logic [$clog2(NBITS)-1:0] idx
);
  localparam int unsigned NW = NBITS / WORD_W;
  localparam int unsigned LW = $clog2(WORD_W);
  localparam int unsigned WW = $clog2(NW);

  logic [NW-1:0] word_any;
  logic [LW-1:0] word_loc [NW];

  genvar w;
  generate
    for (w = 0; w < NW; w++) begin : g_word
      logic [WORD_W-1:0] slice;
      assign slice = bits[w*WORD_W +: WORD_W];
      assign word_any[w] = |slice;
      always_comb begin
        word_loc[w] = '0;
        for (int b = 0; b < WORD_W; b++) begin
          if (slice[b]) word_loc[w] = LW'(b);
        end
      end
    end
  endgenerate

  logic [WW-1:0] wsel;
  always_comb begin
    wsel = '0;
    for (int i = 0; i < NW; i++) begin
      if (word_any[i]) wsel = WW'(i);
    end
  end

  assign any = |word_any;
  assign idx = {wsel, word_loc[wsel]};
endmodule

// File: rtl/irq_prio_ppr.sv
// Derives the processor priority and decides whether the top pending vector may be delivered.
module irq_prio_ppr #(
  parameter int unsigned VEC_W = 8,
  parameter int unsigned CLS_W = 4
) (
  input  logic [VEC_W-1:0] tpr,
  input  logic             isr_any,
  input  logic [VEC_W-1:0] isr_hi,
  input  logic             irr_any,
  input  logic [VEC_W-1:0] irr_hi,
  output logic [VEC_W-1:0] ppr,
  output logic             deliver
);
  localparam int unsigned SUB_W = VEC_W - CLS_W;

  logic [CLS_W-1:0] tpr_cls, isr_cls, irr_cls, ppr_cls;

  assign tpr_cls = tpr[VEC_W-1 -: CLS_W];
  assign isr_cls = isr_hi[VEC_W-1 -: CLS_W];
  assign irr_cls = irr_hi[VEC_W-1 -: CLS_W];

  always_comb begin
    if (!isr_any || tpr_cls >= isr_cls) ppr = tpr;
    else                                ppr = {isr_cls, {SUB_W{1'b0}}};
  end

  assign ppr_cls = ppr[VEC_W-1 -: CLS_W];
  assign deliver = irr_any && (irr_cls > ppr_cls);
endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl #(
  parameter int unsigned NUM_VEC = 256,
  parameter int unsigned WORD_W  = 32,
  parameter int unsigned CLS_W   = 4,
  localparam int unsigned VEC_W  = $clog2(NUM_VEC),
  localparam int unsigned NWORDS = NUM_VEC / WORD_W,
  localparam int unsigned WIDX_W = $clog2(NWORDS),
  localparam int unsigned ADDR_W = WIDX_W + 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              acc_valid,
  input  logic [VEC_W-1:0]  acc_vec,
  input  logic              ack,
  output logic              ack_valid,
  output logic [VEC_W-1:0]  ack_vec,
  input  logic              eoi_wr,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [WORD_W-1:0] reg_wdata,
  output logic [WORD_W-1:0] reg_rdata,
  output logic              irq_req,
  output logic [VEC_W-1:0]  irq_vec
);
  import irq_prio_pkg::*;

  localparam logic [NUM_VEC-1:0] ONE = {{(NUM_VEC-1){1'b0}}, 1'b1};

  logic [NUM_VEC-1:0] irr_q, isr_q;
  logic [VEC_W-1:0]   tpr_q;

  logic               irr_any, isr_any, deliver;
  logic [VEC_W-1:0]   irr_hi, isr_hi, ppr;

  irq_hi_find #(.NBITS(NUM_VEC), .WORD_W(WORD_W)) u_find_irr (
    .bits(irr_q), .any(irr_any), .idx(irr_hi)
  );

  irq_hi_find #(.NBITS(NUM_VEC), .WORD_W(WORD_W)) u_find_isr (
    .bits(isr_q), .any(isr_any), .idx(isr_hi)
  );

  irq_prio_ppr #(.VEC_W(VEC_W), .CLS_W(CLS_W)) u_ppr (
    .tpr(tpr_q), .isr_any(isr_any), .isr_hi(isr_hi),
    .irr_any(irr_any), .irr_hi(irr_hi),
    .ppr(ppr), .deliver(deliver)
  );

  // Update masks; ordering within one edge follows R10.
  logic               take;
  logic               acc_ok;
  logic [NUM_VEC-1:0] ack_mask, acc_mask, eoi_mask;

  assign take     = ack && deliver;
  assign acc_ok   = acc_valid && (acc_vec[VEC_W-1 -: CLS_W] != '0);
  assign ack_mask = take ? (ONE << irr_hi) : '0;
  assign acc_mask = acc_ok ? (ONE << acc_vec) : '0;
  assign eoi_mask = (eoi_wr && isr_any) ? (ONE << isr_hi) : '0;

  // Register port decode.
  bank_e             bank;
  logic [WIDX_W-1:0] widx;
  logic [WORD_W-1:0] rd_mux;
  logic              tpr_wr;

  assign bank   = bank_e'(reg_addr[ADDR_W-1 -: 2]);
  assign widx   = reg_addr[WIDX_W-1:0];
  assign tpr_wr = reg_wr && (reg_addr == ADDR_W'(CTL_TPR));

  always_comb begin
    rd_mux = '0;
    case (bank)
      BANK_CTL: begin
        if (widx == WIDX_W'(CTL_TPR))      rd_mux = WORD_W'(tpr_q);
        else if (widx == WIDX_W'(CTL_PPR)) rd_mux = WORD_W'(ppr);
      end
      BANK_PEND: rd_mux = irr_q[widx*WORD_W +: WORD_W];
      BANK_SERV: rd_mux = isr_q[widx*WORD_W +: WORD_W];
      default:   rd_mux = '0;
    endcase
  end

  logic unused_wdata;
  assign unused_wdata = ^reg_wdata[WORD_W-1:VEC_W];

  always_ff @(posedge clk) begin
    if (rst) begin
      irr_q     <= '0;
      isr_q     <= '0;
      tpr_q     <= '0;
      irq_req   <= 1'b0;
      irq_vec   <= '0;
      ack_valid <= 1'b0;
      ack_vec   <= '0;
      reg_rdata <= '0;
    end else begin
      irr_q     <= (irr_q & ~ack_mask) | acc_mask;
      isr_q     <= (isr_q & ~eoi_mask) | ack_mask;
      if (tpr_wr) tpr_q <= reg_wdata[VEC_W-1:0];
      irq_req   <= deliver;
      irq_vec   <= deliver ? irr_hi : '0;
      ack_valid <= take;
      ack_vec   <= take ? irr_hi : '0;
      reg_rdata <= rd_mux;
    end
  end
endmodule

// File: rtl/irq_prio_ctrl_chk.sv
module irq_prio_ctrl_chk #(
  parameter int unsigned NUM_VEC = 256,
  parameter int unsigned VEC_W   = 8,
  parameter int unsigned CLS_W   = 4
) (
  input logic               clk,
  input logic               rst,
  input logic               irq_req,
  input logic [VEC_W-1:0]   irq_vec,
  input logic               ack_valid,
  input logic [VEC_W-1:0]   ack_vec,
  input logic               eoi_wr,
  input logic [NUM_VEC-1:0] irr,
  input logic [NUM_VEC-1:0] isr,
  input logic               isr_any,
  input logic [VEC_W-1:0]   isr_hi,
  input logic [VEC_W-1:0]   ppr,
  input logic [VEC_W-1:0]   tpr
);
  localparam int unsigned LOW_N = 1 << (VEC_W - CLS_W);

  assert_reset_idle_R1: assert property (@(posedge clk)
    rst |=> (!irq_req && !ack_valid));

  assert_low_never_pending_R3: assert property (@(posedge clk) disable iff (rst)
    irr[LOW_N-1:0] == '0);

  assert_req_above_ppr_R4: assert property (@(posedge clk) disable iff (rst)
    irq_req |-> (irq_vec[VEC_W-1 -: CLS_W] > $past(ppr[VEC_W-1 -: CLS_W])));

  assert_req_unmasked_R5: assert property (@(posedge clk) disable iff (rst)
    irq_req |-> (irq_vec[VEC_W-1 -: CLS_W] > $past(tpr[VEC_W-1 -: CLS_W])));

  assert_ppr_floor_R6: assert property (@(posedge clk) disable iff (rst)
    (ppr >= tpr) && (!isr_any || ppr[VEC_W-1 -: CLS_W] >= isr_hi[VEC_W-1 -: CLS_W]));

  assert_ack_in_service_R7: assert property (@(posedge clk) disable iff (rst)
    ack_valid |-> isr[ack_vec]);

  assert_eoi_retires_R8: assert property (@(posedge clk) disable iff (rst)
    (eoi_wr && isr_any) |=> !isr[$past(isr_hi)]);
endmodule

bind irq_prio_ctrl irq_prio_ctrl_chk #(
  .NUM_VEC(NUM_VEC), .VEC_W(VEC_W), .CLS_W(CLS_W)
) u_chk (
  .clk(clk), .rst(rst), .irq_req(irq_req), .irq_vec(irq_vec),
  .ack_valid(ack_valid), .ack_vec(ack_vec), .eoi_wr(eoi_wr),
  .irr(irr_q), .isr(isr_q), .isr_any(isr_any), .isr_hi(isr_hi),
  .ppr(ppr), .tpr(tpr_q)
);

// File: tb/irq_prio_ctrl_bench.sv
module irq_prio_ctrl_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 256;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        acc_valid = 1'b0;
  logic [7:0]  acc_vec = '0;
  logic        ack = 1'b0;
  logic        eoi_wr = 1'b0;
  logic        reg_wr = 1'b0;
  logic [4:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic        ack_valid, irq_req;
  logic [7:0]  ack_vec, irq_vec;
  logic [31:0] reg_rdata;

  int checks = 0;
  int fails  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_prio_ctrl u_irq_prio_ctrl (
    .clk(clk), .rst(rst), .acc_valid(acc_valid), .acc_vec(acc_vec),
    .ack(ack), .ack_valid(ack_valid), .ack_vec(ack_vec), .eoi_wr(eoi_wr),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .irq_req(irq_req), .irq_vec(irq_vec)
  );

  task automatic check(string tag, longint act, longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  bit m_irr [NV];
  bit m_isr [NV];
  int m_tpr;
  bit chk_on = 0;
  bit e_req, e_ackv;
  int e_vec, e_ackvec;
  longint e_rd;

  function automatic int top_of(input bit a [NV]);
    for (int i = NV - 1; i >= 0; i--) if (a[i]) return i;
    return -1;
  endfunction

  function automatic int prio_now();
    int s;
    s = top_of(m_isr);
    if (s < 0 || (m_tpr / 16) >= (s / 16)) return m_tpr;
    return (s / 16) * 16;
  endfunction

  function automatic longint word_of(input bit a [NV], input int w);
    longint r = 0;
    for (int b = 0; b < 32; b++) if (a[w*32 + b]) r |= (longint'(1) << b);
    return r;
  endfunction

  always @(posedge clk) begin
    int r, s, p, a;
    bit dl;
    chk_on = 1;
    if (rst) begin
      foreach (m_irr[i]) begin m_irr[i] = 0; m_isr[i] = 0; end
      m_tpr = 0; e_req = 0; e_vec = 0; e_ackv = 0; e_ackvec = 0; e_rd = 0;
    end else begin
      r = top_of(m_irr);
      s = top_of(m_isr);
      p = prio_now();
      dl = (r >= 0) && ((r / 16) > (p / 16));
      e_req = dl;
      e_vec = dl ? r : 0;
      e_ackv = ack && dl;
      e_ackvec = e_ackv ? r : 0;
      a = int'(reg_addr);
      if (a == 0)       e_rd = m_tpr;
      else if (a == 1)  e_rd = p;
      else if (a >= 24) e_rd = word_of(m_isr, a - 24);
      else if (a >= 16) e_rd = word_of(m_irr, a - 16);
      else              e_rd = 0;
      if (eoi_wr && s >= 0) m_isr[s] = 0;
      if (e_ackv) begin m_irr[r] = 0; m_isr[r] = 1; end
      if (acc_valid && acc_vec >= 16) m_irr[acc_vec] = 1;
      if (reg_wr && reg_addr == 0) m_tpr = int'(reg_wdata[7:0]);
    end
  end

  always @(negedge clk) begin
    if (chk_on) begin
      check("R4 model irq_req", irq_req, e_req);
      check("R4 model irq_vec", irq_vec, e_vec);
      check("R7 model ack_valid", ack_valid, e_ackv);
      check("R7 model ack_vec", ack_vec, e_ackvec);
      check("R9 model reg_rdata", reg_rdata, e_rd);
    end
  end

  // ---------------- directed stimulus helpers ----------------
  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic accept(int v);
    acc_valid = 1; acc_vec = 8'(v);
    @(negedge clk);
    acc_valid = 0;
  endtask

  task automatic wr_reg(int addr, longint v);
    reg_wr = 1; reg_addr = 5'(addr); reg_wdata = 32'(v);
    @(negedge clk);
    reg_wr = 0; reg_addr = 0;
  endtask

  task automatic rd(int addr, longint exp, string tag);
    reg_addr = 5'(addr);
    @(negedge clk);
    check(tag, reg_rdata, exp);
  endtask

  task automatic do_ack();
    ack = 1;
    @(negedge clk);
    ack = 0;
  endtask

  task automatic do_eoi();
    eoi_wr = 1;
    @(negedge clk);
    eoi_wr = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    cyc(3);
    rst = 0;
    cyc(1);
    check("R1 irq_req after reset", irq_req, 0);
    check("R1 ack_valid after reset", ack_valid, 0);
    rd(0, 0, "R1 task priority after reset");
    rd(23, 0, "R1 pending word7 after reset");

    accept(8'h05); accept(8'h0F);
    rd(16, 0, "R3 class-0 accepts ignored");
    check("R3 no request from class-0", irq_req, 0);

    accept(8'hF3); accept(8'hF3);
    rd(23, 32'h0008_0000, "R2 vector F3 in pending word7");
    check("R4 request for F3", irq_req, 1);
    check("R4 vector F3 presented", irq_vec, 8'hF3);

    wr_reg(0, 8'hF0); cyc(1);
    check("R5 class F masked by F0", irq_req, 0);
    rd(1, 8'hF0, "R6 ppr equals tpr when idle");
    wr_reg(0, 8'hFF); cyc(1);
    check("R5 tpr FF blocks all", irq_req, 0);
    rd(23, 32'h0008_0000, "R5 masked stays pending");
    rd(31, 0, "R5 masked not in service");

    wr_reg(0, 8'h20); accept(8'h41); accept(8'h35); cyc(1);
    check("R4 highest F3 requested", irq_req, 1);
    check("R4 highest vector F3", irq_vec, 8'hF3);
    do_ack();
    check("R7 ack_valid on ack", ack_valid, 1);
    check("R7 ack_vec F3", ack_vec, 8'hF3);
    rd(31, 32'h0008_0000, "R7 F3 now in service");
    rd(23, 0, "R7 F3 left pending");
    rd(1, 8'hF0, "R6 ppr from in-service class");
    check("R4 lower classes held off", irq_req, 0);
    do_ack();
    check("R7 ack with nothing deliverable", ack_valid, 0);
    rd(18, 32'h0000_0002, "R7 idle ack leaves pending");

    do_eoi();
    rd(31, 0, "R8 eoi retires F3");
    check("R8 request re-evaluated", irq_req, 1);
    check("R8 next vector 41", irq_vec, 8'h41);
    do_ack();
    check("R7 ack_vec 41", ack_vec, 8'h41);
    rd(1, 8'h40, "R6 ppr class of 41");
    check("R5 class 3 below ppr", irq_req, 0);

    do_eoi(); cyc(1);
    check("R8 35 deliverable after eoi", irq_vec, 8'h35);
    acc_valid = 1; acc_vec = 8'h35; ack = 1;
    @(negedge clk);
    acc_valid = 0; ack = 0;
    check("R10 ack_vec 35", ack_vec, 8'h35);
    rd(17, 32'h0020_0000, "R10 re-accept stays pending");
    rd(25, 32'h0020_0000, "R10 35 in service");
    do_eoi(); do_eoi();
    rd(25, 0, "R8 eoi on empty set no effect");

    wr_reg(16, 32'hFFFF_FFFF); wr_reg(1, 32'h77);
    rd(16, 0, "R9 pending word write ignored");
    rd(1, 8'h20, "R9 ppr write ignored");
    rd(0, 8'h20, "R9 tpr readback");

    for (int n = 0; n < 3000; n++) begin
      acc_valid = ($urandom_range(0, 1) == 1);
      acc_vec   = 8'($urandom_range(0, 255));
      ack       = ($urandom_range(0, 9) < 3);
      eoi_wr    = ($urandom_range(0, 9) < 2);
      reg_addr  = 5'($urandom_range(0, 31));
      reg_wr    = ($urandom_range(0, 39) == 0);
      reg_wdata = ($urandom_range(0, 7) == 0) ? 32'hFF : 32'($urandom_range(0, 255));
      if (reg_wr && $urandom_range(0, 1) == 1) reg_addr = 0;
      @(negedge clk);
    end
    acc_valid = 0; ack = 0; eoi_wr = 0; reg_wr = 0;
    cyc(2);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule